// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Operand Pre-Shift

This block forms one multiply-accumulate step per clock. It multiplies two signed 16-bit operands and then adds the 32-bit product to a 40-bit accumulator operand, or subtracts it from that operand. Before the adder, the accumulator operand can pass through unchanged. It can also be shifted arithmetically right by one bit, which halves it for scaled accumulation, or by sixteen bits, which moves the high word down to the low word for multi-precision work.

The accumulator operand arrives as three fields that a surrounding register file supplies: a 16-bit low word, a 16-bit high word and an 8-bit guard extension. The result is 40 bits wide and wraps on overflow. No saturation is applied. A flag reports when the wrapped result does not fit the signs of the operands that produced it. The result is registered. A new operation can be issued on every clock, with a valid strobe travelling alongside it.

Top module: `mac40_preshift`

## Requirements
- R1: While reset is asserted, and for the cycles it takes for the release to pass through the internal two-stage synchronizer, `res` is 0, `ovf` is 0 and `res_vld` is 0.
- R2: With `sub_en`=0 and `sh_sel`=00, one clock after `in_vld` is high, `res` equals the accumulator operand plus the signed product `mul_a`*`mul_b`. The product is sign-extended to 40 bits.
- R3: With `sub_en`=1, `res` equals the (shifted) accumulator operand minus the signed product.
- R4: `sh_sel`=01 shifts the accumulator operand arithmetically right by 1 bit, copying bit 39, before the add or subtract.
- R5: `sh_sel`=10 shifts the accumulator operand arithmetically right by 16 bits, filling with bit 39, before the add or subtract.
- R6: `sh_sel`=11 is reserved and gives exactly the same result as 00 (no shift).
- R7: The accumulator operand is {`acc_ext`, `acc_hi`, `acc_lo`}. `acc_ext` supplies bits 39:32, `acc_hi` supplies bits 31:16 and `acc_lo` supplies bits 15:0.
- R8: `res` is the exact sum or difference taken modulo 2^40. `ovf` is 1 exactly when the exact value lies outside [-2^39, 2^39-1].
- R9: `res_vld` is `in_vld` delayed by one clock. In a cycle where `in_vld` is 0, `res` and `ovf` keep their previous values.
- R10: Operations issued on consecutive clocks each produce their own correct result one clock later, with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Operands valid; issues an operation |
| mul_a | input | 16 | Signed multiplicand |
| mul_b | input | 16 | Signed multiplier |
| acc_lo | input | 16 | Accumulator operand bits 15:0 |
| acc_hi | input | 16 | Accumulator operand bits 31:16 |
| acc_ext | input | 8 | Accumulator operand bits 39:32 |
| sub_en | input | 1 | 1: subtract product, 0: add product |
| sh_sel | input | 2 | Pre-shift: 00 none, 01 right 1, 10 right 16, 11 none |
| res | output | 40 | Registered 40-bit result |
| ovf | output | 1 | Registered signed overflow flag |
| res_vld | output | 1 | Result valid, one clock after in_vld |

## Verification
Small hand-picked operands with mixed signs separate signed multiplication from unsigned multiplication, and the subtract cases catch a swapped operand order. Negative accumulator values under each shift code tell an arithmetic shift from a logical one. Distinct values in the three fields expose any misplaced field. Operands chosen to land just past either end of the 40-bit range exercise the wrap and the overflow flag, and a no-overflow case confirms that the flag clears. A long run of random back-to-back operations with idle gaps, compared cycle by cycle against the bench's integer model, checks issue on every clock and the hold behaviour.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_R1   = 2'b01,
    SH_R16  = 2'b10,
    SH_RSV  = 2'b11
  } sh_sel_e;
endpackage

// File: rtl/mac_mul.sv
module mac_mul #(
  parameter int OP_W  = 16,
  parameter int OUT_W = 40
) (
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  output logic [OUT_W-1:0] prod_x
);
  localparam int PW = 2 * OP_W;
  logic signed [PW-1:0] a_x, b_x, p;

  always_comb begin
    a_x    = PW'($signed(a));
    b_x    = PW'($signed(b));
    p      = a_x * b_x;
    prod_x = {{(OUT_W-PW){p[PW-1]}}, p};
  end
endmodule

// File: rtl/mac_preshift.sv
module mac_preshift
  import mac_pkg::*;
#(
  parameter int W     = 40,
  parameter int BIG_SH = 16
) (
  input  logic [W-1:0] din,
  input  logic [1:0]   sel,
  output logic [W-1:0] dout
);
  always_comb begin
    unique case (sh_sel_e'(sel))
      SH_R1:   dout = {din[W-1], din[W-1:1]};
      SH_R16:  dout = {{BIG_SH{din[W-1]}}, din[W-1:BIG_SH]};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/mac_addsub.sv
module mac_addsub #(
  parameter int W = 40
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] p,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ov
);
  logic [W-1:0] p_eff;
  always_comb begin
    p_eff = sub ? ~p : p;
    sum   = x + p_eff + W'(sub);
    // two's complement: inputs of equal effective sign, result sign differs
    ov    = (x[W-1] == p_eff[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/mac40_preshift.sv
module mac40_preshift #(
  parameter int OP_W   = 16,
  parameter int ACC_W  = 40,
  parameter int BIG_SH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_vld,
  input  logic [OP_W-1:0]           mul_a,
  input  logic [OP_W-1:0]           mul_b,
  input  logic [OP_W-1:0]           acc_lo,
  input  logic [OP_W-1:0]           acc_hi,
  input  logic [ACC_W-2*OP_W-1:0]   acc_ext,
  input  logic                      sub_en,
  input  logic [1:0]                sh_sel,
  output logic [ACC_W-1:0]          res,
  output logic                      ovf,
  output logic                      res_vld
);
  localparam int EXT_W = ACC_W - 2*OP_W;

  // reset synchronizer: assert asynchronously, release on clock
  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic [ACC_W-1:0] acc_op, acc_sh, prod_x, sum_d;
  logic             ov_d;

  assign acc_op = {acc_ext, acc_hi, acc_lo};

  mac_mul #(.OP_W(OP_W), .OUT_W(ACC_W)) u_mul (
    .a(mul_a), .b(mul_b), .prod_x(prod_x)
  );

  mac_preshift #(.W(ACC_W), .BIG_SH(BIG_SH)) u_shift (
    .din(acc_op), .sel(sh_sel), .dout(acc_sh)
  );

  mac_addsub #(.W(ACC_W)) u_add (
    .x(acc_sh), .p(prod_x), .sub(sub_en), .sum(sum_d), .ov(ov_d)
  );

  // next-state
  logic [ACC_W-1:0] res_n;
  logic             ovf_n, vld_n;
  always_comb begin
    res_n = res;
    ovf_n = ovf;
    vld_n = in_vld;
    if (in_vld) begin
      res_n = sum_d;
      ovf_n = ov_d;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res     <= '0;
      ovf     <= 1'b0;
      res_vld <= 1'b0;
    end else begin
      res     <= res_n;
      ovf     <= ovf_n;
      res_vld <= vld_n;
    end
  end

  logic unused_ok;
  assign unused_ok = ^{EXT_W[0]};
endmodule

// File: rtl/mac40_preshift_chk.sv
module mac40_preshift_chk #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_vld,
  input logic [OP_W-1:0]         mul_a,
  input logic [OP_W-1:0]         mul_b,
  input logic [OP_W-1:0]         acc_lo,
  input logic [OP_W-1:0]         acc_hi,
  input logic [ACC_W-2*OP_W-1:0] acc_ext,
  input logic                    sub_en,
  input logic [1:0]              sh_sel,
  input logic [ACC_W-1:0]        res,
  input logic                    ovf,
  input logic                    res_vld
);
  logic signed [ACC_W-1:0] c_acc, c_prod, c_add, c_sub;
  always_comb begin
    c_acc  = {acc_ext, acc_hi, acc_lo};
    c_prod = ACC_W'($signed(mul_a)) * ACC_W'($signed(mul_b));
    c_add  = c_acc + c_prod;
    c_sub  = c_acc - c_prod;
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld == $past(in_vld));
  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(res) && $stable(ovf)));
  // R2
  add_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !sub_en && sh_sel == 2'b00) |=> res == $past(c_add));
  // R3
  sub_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && sub_en && sh_sel == 2'b00) |=> res == $past(c_sub));
  // R6
  rsv_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !sub_en && sh_sel == 2'b11) |=> res == $past(c_add));
  // R8
  add_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !sub_en && sh_sel == 2'b00) |=>
      ovf == (($past(c_acc[ACC_W-1]) == $past(c_prod[ACC_W-1])) &&
              (res[ACC_W-1] != $past(c_acc[ACC_W-1]))));
endmodule

bind mac40_preshift mac40_preshift_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .in_vld(in_vld), .mul_a(mul_a), .mul_b(mul_b),
  .acc_lo(acc_lo), .acc_hi(acc_hi), .acc_ext(acc_ext), .sub_en(sub_en),
  .sh_sel(sh_sel), .res(res), .ovf(ovf), .res_vld(res_vld)
);

// File: tb/mac40_preshift_tb_top.sv
module mac40_preshift_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [15:0] mul_a, mul_b, acc_lo, acc_hi;
  logic [7:0]  acc_ext;
  logic        sub_en;
  logic [1:0]  sh_sel;
  logic [39:0] res;
  logic        ovf, res_vld;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [39:0] m_res = '0;
  logic        m_ovf = 1'b0;

  always #5 clk = ~clk;

  mac40_preshift dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mul_a(mul_a), .mul_b(mul_b),
    .acc_lo(acc_lo), .acc_hi(acc_hi), .acc_ext(acc_ext), .sub_en(sub_en),
    .sh_sel(sh_sel), .res(res), .ovf(ovf), .res_vld(res_vld)
  );

  function automatic longint sx40(input logic [39:0] v);
    return longint'({{24{v[39]}}, v});
  endfunction

  task automatic check(input string tag, input logic [39:0] er,
                       input logic eo, input logic ev);
    n_run++;
    if (res !== er || ovf !== eo || res_vld !== ev) begin
      n_fail++;
      $display("FAIL %s: res=%h ovf=%b vld=%b expected res=%h ovf=%b vld=%b",
               tag, res, ovf, res_vld, er, eo, ev);
    end
  endtask

  // one operation: drive at negedge, result checked at next negedge
  task automatic op(input string tag, input logic v, input logic [39:0] acc,
                    input logic [15:0] a, input logic [15:0] b,
                    input logic s, input logic [1:0] sh);
    longint x, p, t;
    in_vld = v; mul_a = a; mul_b = b; sub_en = s; sh_sel = sh;
    acc_lo = acc[15:0]; acc_hi = acc[31:16]; acc_ext = acc[39:32];
    if (v) begin
      x = sx40(acc);
      if (sh == 2'b01) x = x >>> 1;
      else if (sh == 2'b10) x = x >>> 16;
      p = longint'($signed(a)) * longint'($signed(b));
      t = s ? x - p : x + p;
      m_res = t[39:0];
      m_ovf = (t > 64'sh7F_FFFF_FFFF) || (t < -64'sh80_0000_0000);
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, m_res, m_ovf, v);
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; mul_a = '0; mul_b = '0; acc_lo = '0;
    acc_hi = '0; acc_ext = '0; sub_en = 1'b0; sh_sel = 2'b00;
    repeat (3) @(negedge clk);
    check("R1 in reset", 40'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 40'h0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);

    op("R2 small positive", 1, 40'd100, 16'd3, 16'd4, 0, 2'b00);
    op("R2 mixed sign", 1, 40'd0, -16'sd5, 16'd7, 0, 2'b00);
    op("R2 both negative", 1, 40'd0, 16'h8000, 16'h8000, 0, 2'b00);
    op("R3 subtract", 1, 40'd1000, 16'd10, 16'd10, 1, 2'b00);
    op("R3 subtract negative product", 1, 40'd5, -16'sd2, 16'd9, 1, 2'b00);
    op("R4 shift1 negative", 1, 40'hFF_FFFF_FFFD, 16'd0, 16'd0, 0, 2'b01);
    op("R4 shift1 positive", 1, 40'h00_0001_2345, 16'd2, 16'd3, 0, 2'b01);
    op("R5 shift16 negative", 1, 40'h80_0000_0000, 16'd1, 16'd1, 0, 2'b10);
    op("R5 shift16 positive", 1, 40'h12_3456_789A, 16'd4, 16'd4, 1, 2'b10);
    op("R6 reserved code", 1, 40'hF0_0000_0001, 16'd6, 16'd6, 0, 2'b11);
    op("R7 field placement", 1, 40'h33_2222_1111, 16'd0, 16'd5, 0, 2'b00);
    op("R8 positive wrap", 1, 40'h7F_FFFF_FFFF, 16'd1, 16'd1, 0, 2'b00);
    op("R8 negative wrap", 1, 40'h80_0000_0000, 16'd1, 16'd1, 1, 2'b00);
    op("R8 no overflow", 1, 40'h7F_FFFF_FFFF, 16'd1, 16'd1, 1, 2'b00);
    op("R9 idle hold", 0, 40'h55_5555_5555, 16'd9, 16'd9, 0, 2'b00);
    op("R9 idle hold again", 0, 40'h0, 16'd1, 16'd1, 1, 2'b01);

    for (int i = 0; i < 400; i++) begin
      logic [39:0] r_acc;
      r_acc = {$urandom(), $urandom()};
      op("R10 back-to-back", ($urandom_range(0, 7) != 0), r_acc,
         16'($urandom()), 16'($urandom()), 1'($urandom()),
         2'($urandom()));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule